// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the operating-mode state machine of a single-wire vehicle bus transceiver. It takes four inputs: a supply-above-reset flag, an enable input from the protocol controller, and two pre-validated wakeup pulses, one local and one from the bus. From these it picks one of four modes: off, standby, normal and sleep. In each mode it drives the control outputs of the analog front end. These are the transmitter enable, the regulator inhibit switch, the receive-pin pull-low, the transmit-pin strong pulldown, the bus termination select, and a window flag that tells the wake detector when it may report events.

The enable input is glitch-filtered by two run-length counters whose lengths are clock-cycle parameters. After a wakeup, the receive and transmit pins are reused in standby to report that a wakeup happened and which kind it was. This reporting is withdrawn on the first clock edge that samples the enable high, well before the enable filter completes the move to normal.

Top module: `lin_mode_ctrl`

## Requirements
- R1: Reset, or a low `supply_ok` sampled at any edge, puts the block in off (mode code 0). In off, all of `tx_en_o`, `inh_on_o`, `rxd_low_o`, `txd_strong_o` and `wake_window_o` are 0, and `term_sel_o` is 0 (floating).
- R2: In off, a high `supply_ok` moves the block to standby (mode code 1) at the next edge. No wakeup is reported: `rxd_low_o`=0 and `txd_strong_o`=0.
- R3: Standby or sleep moves to normal (mode code 2) at the edge that takes the EN_ON_CYC-th consecutive high sample of `en_in`. Any low sample before that restarts the count.
- R4: Normal moves to sleep (mode code 3) at the edge that takes the EN_OFF_CYC-th consecutive low sample of `en_in`. Any high sample before that restarts the count.
- R5: In standby, the first edge that samples `en_in` high clears the wakeup report (`rxd_low_o`=0, `txd_strong_o`=0). The mode stays standby until R3 completes.
- R6: A wake pulse sampled in sleep, or in normal while `en_in` is low, moves the block to standby with `rxd_low_o`=1. `txd_strong_o` is 1 for a local wake and 0 for a bus wake. A local wake wins when both pulses arrive together.
- R7: In normal, a wake on the same edge that would complete R4 wins, and the block goes to standby. In sleep, completion of R3 wins over a simultaneous wake, and the block goes to normal.
- R8: Wake pulses in off, in standby, and in normal with `en_in` high change neither the mode nor any pin output.
- R9: Standby drives `inh_on_o`=1, `term_sel_o`=1 (resistor) and `tx_en_o`=0. Normal drives `tx_en_o`=1, `inh_on_o`=1, `term_sel_o`=1, `txd_strong_o`=0, with `rxd_low_o` equal to `bus_dom`. Sleep drives `inh_on_o`=0, `term_sel_o`=2 (current source), `tx_en_o`=0, `rxd_low_o`=0 and `txd_strong_o`=0.
- R10: `wake_window_o` is 1 in sleep, and in normal while `en_in` is low. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above power-on-reset level |
| en_in | input | 1 | Mode enable from protocol controller |
| wake_local | input | 1 | Validated local wakeup pulse |
| wake_bus | input | 1 | Validated bus wakeup pulse |
| bus_dom | input | 1 | Received bus symbol is dominant |
| mode_o | output | 2 | Current mode: 0 off, 1 standby, 2 normal, 3 sleep |
| tx_en_o | output | 1 | Transmitter enable |
| inh_on_o | output | 1 | Regulator inhibit switch closed |
| rxd_low_o | output | 1 | Receive pin pulled low |
| txd_strong_o | output | 1 | Strong pulldown on transmit pin |
| term_sel_o | output | 2 | Termination: 0 floating, 1 resistor, 2 current source |
| wake_window_o | output | 1 | Wake detector may report events |

## Verification
Two pairs of events can land on the same edge. In normal, a wake pulse can coincide with the final sample of the disable filter. In sleep, a wake pulse can coincide with the final sample of the enable filter. The bench provokes each pair by holding the enable level for exactly one sample short of the filter length and raising the wake pulse on the next sample. It then judges the mode and the reported wake source after that edge against R7. Sweeps over every shorter run length confirm that neither filter fires early or fails to restart.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_NORM  = 2'd2,
        MODE_SLEEP = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_BUS   = 2'd2
    } wsrc_t;

    typedef enum logic [1:0] {
        TERM_FLOAT  = 2'd0,
        TERM_RES    = 2'd1,
        TERM_CURSRC = 2'd2
    } term_t;

    typedef struct packed {
        logic  tx_en;
        logic  inh_on;
        logic  rxd_low;
        logic  txd_strong;
        term_t term;
        logic  window;
    } pins_t;

    function automatic wsrc_t pick_src(input logic loc, input logic bus);
        if (loc)      return SRC_LOCAL;
        else if (bus) return SRC_BUS;
        else          return SRC_NONE;
    endfunction

endpackage

// File: rtl/lin_en_filter.sv
module lin_en_filter #(
    parameter int HI_CYC = 50,
    parameter int LO_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic hi_done,
    output logic lo_done
);
    localparam int HW = $clog2(HI_CYC + 1);
    localparam int LW = $clog2(LO_CYC + 1);
    localparam logic [HW-1:0] HI_TOP = HW'(HI_CYC - 1);
    localparam logic [LW-1:0] LO_TOP = LW'(LO_CYC - 1);

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;

    assign hi_done = en_in && (hi_cnt == HI_TOP);
    assign lo_done = !en_in && (lo_cnt == LO_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= !en_in ? '0 : ((hi_cnt == HI_TOP) ? hi_cnt : hi_cnt + 1'b1);
            lo_cnt <=  en_in ? '0 : ((lo_cnt == LO_TOP) ? lo_cnt : lo_cnt + 1'b1);
        end
    end

    p_hi_restart_r3: assert property (@(posedge clk) disable iff (rst)
        !en_in |=> !hi_done);
    p_lo_restart_r4: assert property (@(posedge clk) disable iff (rst)
        en_in |=> !lo_done);

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  supply_ok,
    input  logic  en_in,
    input  logic  hi_done,
    input  logic  lo_done,
    input  logic  wake_local,
    input  logic  wake_bus,
    output mode_t mode_q,
    output wsrc_t src_q
);
    mode_t mode_n;
    wsrc_t src_n;
    logic  wake_any;

    assign wake_any = wake_local || wake_bus;

    always_comb begin
        mode_n = mode_q;
        src_n  = src_q;
        unique case (mode_q)
            MODE_OFF: begin
                if (supply_ok) mode_n = MODE_STBY;
            end
            MODE_STBY: begin
                if (en_in)   src_n  = SRC_NONE;
                if (hi_done) mode_n = MODE_NORM;
            end
            MODE_NORM: begin
                if (!en_in && wake_any) begin
                    mode_n = MODE_STBY;
                    src_n  = pick_src(wake_local, wake_bus);
                end else if (lo_done) begin
                    mode_n = MODE_SLEEP;
                end
            end
            MODE_SLEEP: begin
                if (hi_done) begin
                    mode_n = MODE_NORM;
                end else if (wake_any) begin
                    mode_n = MODE_STBY;
                    src_n  = pick_src(wake_local, wake_bus);
                end
            end
            default: mode_n = MODE_OFF;
        endcase
        if (!supply_ok) begin
            mode_n = MODE_OFF;
            src_n  = SRC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            src_q  <= SRC_NONE;
        end else begin
            mode_q <= mode_n;
            src_q  <= src_n;
        end
    end

    p_supply_loss_r1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> mode_q == MODE_OFF);
    p_powerup_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF && supply_ok) |=> (mode_q == MODE_STBY && src_q == SRC_NONE));
    p_norm_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_NORM && !en_in) |=> mode_q != MODE_NORM);
    p_sleep_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORM && en_in) |=> mode_q != MODE_SLEEP);
    p_local_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLEEP && supply_ok && !en_in && wake_local)
        |=> (mode_q == MODE_STBY && src_q == SRC_LOCAL));
    p_wake_beats_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORM && supply_ok && !en_in && wake_any) |=> mode_q == MODE_STBY);
    p_stby_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STBY && supply_ok && !en_in) |=> $stable(src_q));

endmodule

// File: rtl/lin_pin_cfg.sv
module lin_pin_cfg
    import lin_mode_pkg::*;
(
    input  mode_t mode,
    input  wsrc_t src,
    input  logic  bus_dom,
    input  logic  en_in,
    output pins_t pins
);
    always_comb begin
        pins = '{tx_en: 1'b0, inh_on: 1'b0, rxd_low: 1'b0, txd_strong: 1'b0,
                 term: TERM_FLOAT, window: 1'b0};
        unique case (mode)
            MODE_STBY: begin
                pins.inh_on     = 1'b1;
                pins.term       = TERM_RES;
                pins.rxd_low    = (src != SRC_NONE);
                pins.txd_strong = (src == SRC_LOCAL);
            end
            MODE_NORM: begin
                pins.tx_en   = 1'b1;
                pins.inh_on  = 1'b1;
                pins.term    = TERM_RES;
                pins.rxd_low = bus_dom;
                pins.window  = !en_in;
            end
            MODE_SLEEP: begin
                pins.term   = TERM_CURSRC;
                pins.window = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        a_strong_only_stby_r9: assert (!pins.txd_strong || mode == MODE_STBY);
        a_window_modes_r10: assert (!pins.window || mode == MODE_SLEEP || mode == MODE_NORM);
    end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int EN_ON_CYC  = 50,
    parameter int EN_OFF_CYC = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       en_in,
    input  logic       wake_local,
    input  logic       wake_bus,
    input  logic       bus_dom,
    output logic [1:0] mode_o,
    output logic       tx_en_o,
    output logic       inh_on_o,
    output logic       rxd_low_o,
    output logic       txd_strong_o,
    output logic [1:0] term_sel_o,
    output logic       wake_window_o
);
    logic  hi_done, lo_done;
    mode_t mode_q;
    wsrc_t src_q;
    pins_t pins;

    lin_en_filter #(.HI_CYC(EN_ON_CYC), .LO_CYC(EN_OFF_CYC)) filt_i (
        .clk(clk), .rst(rst), .en_in(en_in), .hi_done(hi_done), .lo_done(lo_done)
    );

    lin_mode_fsm fsm_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_in(en_in),
        .hi_done(hi_done), .lo_done(lo_done),
        .wake_local(wake_local), .wake_bus(wake_bus),
        .mode_q(mode_q), .src_q(src_q)
    );

    lin_pin_cfg pin_i (
        .mode(mode_q), .src(src_q), .bus_dom(bus_dom), .en_in(en_in), .pins(pins)
    );

    assign mode_o        = mode_q;
    assign tx_en_o       = pins.tx_en;
    assign inh_on_o      = pins.inh_on;
    assign rxd_low_o     = pins.rxd_low;
    assign txd_strong_o  = pins.txd_strong;
    assign term_sel_o    = pins.term;
    assign wake_window_o = pins.window;

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> !(inh_on_o || tx_en_o || rxd_low_o || wake_window_o));
    p_tx_only_norm_r9: assert property (@(posedge clk) disable iff (rst)
        tx_en_o |-> mode_o == 2'd2);

endmodule

// File: tb/lin_mode_ctrl_tb_top.sv
module lin_mode_ctrl_tb_top;
    localparam int CLK_PER = 10;
    localparam int ON_N  = 4;
    localparam int OFF_N = 5;

    logic clk = 1'b0;
    logic rst, supply_ok, en_in, wake_local, wake_bus, bus_dom;
    logic [1:0] mode_o, term_sel_o;
    logic tx_en_o, inh_on_o, rxd_low_o, txd_strong_o, wake_window_o;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    lin_mode_ctrl #(.EN_ON_CYC(ON_N), .EN_OFF_CYC(OFF_N)) dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_in(en_in),
        .wake_local(wake_local), .wake_bus(wake_bus), .bus_dom(bus_dom),
        .mode_o(mode_o), .tx_en_o(tx_en_o), .inh_on_o(inh_on_o),
        .rxd_low_o(rxd_low_o), .txd_strong_o(txd_strong_o),
        .term_sel_o(term_sel_o), .wake_window_o(wake_window_o)
    );

    // mode: 0 off 1 stby 2 norm 3 sleep; src: 0 none 1 local 2 bus
    function automatic logic [8:0] expv(input int m, input int s, input logic bd, input logic en);
        logic tx, inh, rl, st, w; logic [1:0] tm;
        tx = 0; inh = 0; rl = 0; st = 0; w = 0; tm = 0;
        case (m)
            1: begin inh = 1; tm = 1; rl = (s != 0); st = (s == 1); end
            2: begin tx = 1; inh = 1; tm = 1; rl = bd; w = !en; end
            3: begin tm = 2; w = 1; end
            default: ;
        endcase
        return {m[1:0], tx, inh, rl, st, tm, w};
    endfunction

    task automatic chk(input string tag, input int m, input int s);
        logic [8:0] a, e;
        a = {mode_o, tx_en_o, inh_on_o, rxd_low_o, txd_strong_o, term_sel_o, wake_window_o};
        e = expv(m, s, bus_dom, en_in);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, a, e);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wake_pulse(input logic loc, input logic bus);
        wake_local = loc; wake_bus = bus;
        tick(1);
        wake_local = 0; wake_bus = 0;
    endtask

    initial begin
        #(CLK_PER * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; supply_ok = 0; en_in = 0; wake_local = 0; wake_bus = 0; bus_dom = 0;
        tick(2);
        chk("R1 reset", 0, 0);
        rst = 0;
        tick(1);
        chk("R1 supply low", 0, 0);
        wake_pulse(1, 1);
        chk("R8 wake in off", 0, 0);
        supply_ok = 1;
        tick(1);
        chk("R2 powerup", 1, 0);

        // R3 sweep from standby: short high runs restart
        for (int k = 1; k < ON_N; k++) begin
            en_in = 1;
            tick(k);
            chk("R3 stby short", 1, 0);
            en_in = 0;
            tick(1);
        end
        en_in = 1;
        tick(ON_N);
        chk("R3 stby to norm", 2, 0);

        for (int b = 0; b < 2; b++) begin
            bus_dom = b[0];
            #1 chk("R9 norm rxd follows bus", 2, 0);
        end
        bus_dom = 0;
        wake_pulse(1, 0);
        chk("R8 wake norm en high", 2, 0);

        // R4 sweep: short low runs restart
        for (int k = 1; k < OFF_N; k++) begin
            en_in = 0;
            #1 chk("R10 window during disable", 2, 0);
            tick(k);
            chk("R4 norm short", 2, 0);
            en_in = 1;
            tick(1);
        end
        en_in = 0;
        tick(OFF_N);
        chk("R4 norm to sleep", 3, 0);
        chk("R10 sleep window", 3, 0);

        // wake sources from sleep, then release and re-entry
        for (int w = 0; w < 3; w++) begin
            int es;
            es = (w == 1) ? 2 : 1;
            wake_pulse(w != 1, w != 0);
            chk("R6 sleep wake", 1, es);
            wake_pulse(w == 1, w != 1);
            chk("R8 stby extra wake", 1, es);
            en_in = 1;
            tick(1);
            chk("R5 release on en", 1, 0);
            tick(ON_N - 1);
            chk("R3 stby to norm after wake", 2, 0);
            en_in = 0;
            tick(2);
            wake_pulse(0, 1);
            chk("R6 wake during disable", 1, 2);
            en_in = 1;
            tick(ON_N);
            en_in = 0;
            tick(OFF_N - 1);
            wake_pulse(1, 0);
            chk("R7 wake beats sleep", 1, 1);
            en_in = 1;
            tick(ON_N);
            en_in = 0;
            tick(OFF_N);
            chk("R4 back to sleep", 3, 0);
        end

        // R3 sweep from sleep and R7 precedence in sleep
        for (int k = 1; k < ON_N; k++) begin
            en_in = 1;
            tick(k);
            chk("R3 sleep short", 3, 0);
            en_in = 0;
            tick(1);
        end
        en_in = 1;
        tick(ON_N - 1);
        wake_pulse(0, 1);
        chk("R7 enable beats wake", 2, 0);

        supply_ok = 0;
        tick(1);
        chk("R1 supply loss in norm", 0, 0);
        supply_ok = 1;
        en_in = 0;
        tick(1);
        chk("R2 repowered quiet", 1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule